// File: doc/BRIEF.md
# Three-Shape Sample Code Generator

This block produces an 8-bit unsigned sample stream for a digital-to-analog converter. It can produce a square, a triangle or a sine shape. A prescaler on the system clock raises a one-cycle enable every `CLK_DIV` clocks. Each enable advances a shared 4-bit phase index, so one period of any shape spans 16 points. The default `CLK_DIV` of 5,000,000 at a 40 MHz clock gives a step rate of 8 Hz and a period of 2 s.

All three shapes are derived in parallel from the same index. A 2-bit select code chooses which one is registered onto the output bus. The bus always shows the code for the phase index on `phase_o`. Every register sits on the single input clock and uses clock enables; no derived clock exists. The converter itself and any display of the codes belong elsewhere.

Top module: `wavegen_top`

## Requirements
- R1: While `rst` is high, and right after it falls, `phase_o` is 0 and `step_o` is 0. `sample_o` is 0 while reset is held. On every clock after reset, `sample_o` reflects the select for index 0 until the first step.
- R2: The phase index advances by exactly one every `CLK_DIV` clock cycles after reset and holds its value in between. With the defaults this gives 16 steps in 80,000,000 cycles of a 40 MHz clock, which is 2 s.
- R3: `step_o` is high for exactly one clock, in the first cycle that shows a new phase index, and is low otherwise.
- R4: After index 15 the phase index returns to 0.
- R5: Select 2'b00 (square) gives 255 for indices 0 through 7 and 0 for indices 8 through 15.
- R6: Select 2'b01 (triangle) gives 32·k for index k from 0 to 7, 255 at index 8, and 32·(16−k) for k from 9 to 15.
- R7: Select 2'b10 (sine) gives round(127.5 + 127.5·sin(2πk/16)), rounding halves upward: 128,176,218,245,255,245,218,176,128,79,37,10,0,10,37,79.
- R8: Select 2'b11 forces `sample_o` to 0.
- R9: A change of `wave_sel` shows on `sample_o` after the next rising clock edge. It does not alter the phase index or the step timing.
- R10: Asserting reset in the middle of a period restarts the index, the prescaler and the strobe from their starting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst | input | 1 | Asynchronous reset, active high |
| wave_sel | input | 2 | Shape choice: 00 square, 01 triangle, 10 sine, 11 zero |
| sample_o | output | 8 | Registered sample code for the converter |
| phase_o | output | 4 | Current phase index 0 to 15 |
| step_o | output | 1 | One-cycle pulse marking a new phase index |

## Verification
A wrong prescaler count shows up as a step that is early or late. It appears at `step_o` and `phase_o` within one step interval, which is five clocks when the bench uses its shortened divider. A corrupted phase register or table entry changes `sample_o` in the very next cycle for the selected shape. Comparing the outputs against a behavioural model on every clock therefore catches it within one period of 16 steps. A select path that sampled the index late, or that disturbed the counter, would show as a one-cycle mismatch right after a select change.

// File: rtl/wavegen_pkg.sv
package wavegen_pkg;

    localparam int SAMPLE_W   = 8;
    localparam int PHASE_W    = 4;
    localparam int NPOINTS    = 1 << PHASE_W;
    localparam int SAMPLE_MAX = (1 << SAMPLE_W) - 1;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [PHASE_W-1:0]  phase_t;

    typedef enum logic [1:0] {
        WSEL_SQUARE = 2'b00,
        WSEL_TRI    = 2'b01,
        WSEL_SINE   = 2'b10,
        WSEL_OFF    = 2'b11
    } wsel_e;

    typedef struct packed {
        sample_t sample;
        logic    step;
    } out_state_t;

    // Quarter-symmetric sine codes centred on 128, halves rounded up
    function automatic sample_t sine_code(input phase_t k);
        sample_t v;
        case (k)
            4'd0:    v = 8'd128;
            4'd1:    v = 8'd176;
            4'd2:    v = 8'd218;
            4'd3:    v = 8'd245;
            4'd4:    v = 8'd255;
            4'd5:    v = 8'd245;
            4'd6:    v = 8'd218;
            4'd7:    v = 8'd176;
            4'd8:    v = 8'd128;
            4'd9:    v = 8'd79;
            4'd10:   v = 8'd37;
            4'd11:   v = 8'd10;
            4'd12:   v = 8'd0;
            4'd13:   v = 8'd10;
            4'd14:   v = 8'd37;
            default: v = 8'd79;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/wavegen_prescaler.sv
module wavegen_prescaler #(
    parameter int CLK_DIV = 5000000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        tick_o  = (count_q == LAST);
        count_d = tick_o ? '0 : count_q + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= LAST);

    // R2
    count_restart_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (count_q == '0));

endmodule

// File: rtl/wavegen_phase.sv
module wavegen_phase
    import wavegen_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_i,
    output phase_t phase_o,
    output phase_t phase_nx_o
);
    phase_t phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (tick_i) phase_d = phase_q + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_d;
    end

    assign phase_o    = phase_q;
    assign phase_nx_o = phase_d;

    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(phase_q));

    // R4
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && phase_q == phase_t'(NPOINTS - 1)) |=> (phase_q == '0));

endmodule

// File: rtl/wavegen_shapes.sv
module wavegen_shapes
    import wavegen_pkg::*;
(
    input  phase_t  idx_i,
    output sample_t square_o,
    output sample_t tri_o,
    output sample_t sine_o
);
    localparam int HALF = NPOINTS / 2;
    localparam int STEP_SH = SAMPLE_W - (PHASE_W - 1);

    phase_t mirror;

    always_comb begin
        mirror   = phase_t'(NPOINTS) - idx_i;
        square_o = (idx_i < phase_t'(HALF)) ? sample_t'(SAMPLE_MAX) : '0;
        if (idx_i == phase_t'(HALF))
            tri_o = sample_t'(SAMPLE_MAX);
        else if (idx_i < phase_t'(HALF))
            tri_o = {idx_i[PHASE_W-2:0], {STEP_SH{1'b0}}};
        else
            tri_o = {mirror[PHASE_W-2:0], {STEP_SH{1'b0}}};
        sine_o   = sine_code(idx_i);
    end

endmodule

// File: rtl/wavegen_top.sv
module wavegen_top
    import wavegen_pkg::*;
#(
    parameter int CLK_DIV = 5000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] wave_sel,
    output logic [7:0] sample_o,
    output logic [3:0] phase_o,
    output logic       step_o
);
    logic       tick;
    phase_t     phase_q, phase_nx;
    sample_t    sq_w, tri_w, sin_w;
    out_state_t st_d, st_q;

    wavegen_prescaler #(.CLK_DIV(CLK_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    wavegen_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .phase_o    (phase_q),
        .phase_nx_o (phase_nx)
    );

    wavegen_shapes u_shapes (
        .idx_i    (phase_nx),
        .square_o (sq_w),
        .tri_o    (tri_w),
        .sine_o   (sin_w)
    );

    always_comb begin
        st_d.step = tick;
        case (wsel_e'(wave_sel))
            WSEL_SQUARE: st_d.sample = sq_w;
            WSEL_TRI:    st_d.sample = tri_w;
            WSEL_SINE:   st_d.sample = sin_w;
            default:     st_d.sample = '0;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sample_o = st_q.sample;
    assign phase_o  = phase_q;
    assign step_o   = st_q.step;

    // R8
    off_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wave_sel == 2'b11) |=> (sample_o == 8'd0));

    // R5
    square_level_chk: assert property (@(posedge clk) disable iff (rst)
        (wave_sel == 2'b00) |=> (sample_o == 8'd0 || sample_o == 8'd255));

    // R3
    step_moves_phase_chk: assert property (@(posedge clk) disable iff (rst)
        step_o |-> (phase_o != $past(phase_o)));

    generate
        if (CLK_DIV > 1) begin : g_pulse
            // R3
            step_single_chk: assert property (@(posedge clk) disable iff (rst)
                step_o |=> !step_o);
        end
    endgenerate

endmodule

// File: tb/wavegen_top_tb.sv
`timescale 1ns/1ps
module wavegen_top_tb_top;
    localparam int DIV = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] wave_sel = 2'b00;
    logic [7:0] sample_o;
    logic [3:0] phase_o;
    logic       step_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string ovr = "";

    // model state
    int m_cnt = 0, m_ph = 0, m_stp = 0, m_sel = 0, m_valid = 0;

    always #2.5 clk = ~clk;

    wavegen_top #(.CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .wave_sel(wave_sel),
        .sample_o(sample_o), .phase_o(phase_o), .step_o(step_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_ph = 0; m_stp = 0; m_valid = 0;
        end else begin
            m_cnt = m_cnt + 1;
            m_stp = 0;
            if (m_cnt == DIV) begin
                m_cnt = 0;
                m_ph  = (m_ph + 1) % 16;
                m_stp = 1;
            end
            m_sel   = int'(wave_sel);
            m_valid = 1;
        end
    end

    function automatic int ref_code(int sel, int k);
        real r;
        case (sel)
            0: return (k < 8) ? 255 : 0;
            1: begin
                if (k < 8)       return 32 * k;
                else if (k == 8) return 255;
                else             return 32 * (16 - k);
            end
            2: begin
                r = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * k / 16.0);
                return int'($floor(r + 0.5));
            end
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare all outputs against the model at a falling edge
    task automatic cycle_check();
        string st;
        @(negedge clk);
        if (rst) begin
            chk("R1 phase", phase_o, 0);
            chk("R1 step", step_o, 0);
            chk("R1 sample", sample_o, 0);
            return;
        end
        case (m_sel)
            0: st = "R5";
            1: st = "R6";
            2: st = "R7";
            default: st = "R8";
        endcase
        if (ovr != "") st = ovr;
        chk((m_stp && m_ph == 0) ? "R4 phase" : "R2 phase", phase_o, m_ph);
        chk("R3 step", step_o, m_stp);
        chk(st, sample_o, m_valid ? ref_code(m_sel, m_ph) : 0);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle_check();
    endtask

    initial begin
        // R1: reset state
        run(3);
        @(negedge clk); rst = 1'b0;
        ovr = "R1"; run(3); ovr = "";
        // R5 square across two periods with wrap (R4)
        run(2 * 16 * DIV);
        // R6 triangle
        wave_sel = 2'b01; run(16 * DIV + 3);
        // R7 sine
        wave_sel = 2'b10; run(16 * DIV + 7);
        // R8 off
        wave_sel = 2'b11; run(16 * DIV);
        // R9: select changes mid-step every few clocks
        ovr = "R9";
        for (int i = 0; i < 40; i++) begin
            wave_sel = 2'(i % 4);
            run(3);
        end
        ovr = "";
        // R10: reset in the middle of a period
        wave_sel = 2'b01;
        run(2 * DIV + 2);
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        ovr = "R10"; run(16 * DIV + 4); ovr = "";
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule